// File: doc/BRIEF.md
# OUT Endpoint Buffer Ownership Controller

This block decides who owns the data buffer of one USB OUT endpoint: the serial interface engine (SIE) that fills it from the bus, or the firmware CPU that drains it. A single busy flag records ownership. Firmware hands the buffer to the SIE by writing any value to the byte-count register. The SIE gives it back when a packet arrives intact and is acknowledged. A packet that fails the accuracy check leaves the buffer with the SIE, so the host's retry needs no help from firmware.

When each OUT transaction ends, the block picks one of four handshake answers: ACK, NAK, STALL or silence. It latches the received byte count of every acknowledged packet. It raises an interrupt request when the busy flag falls. A fast status register shows this endpoint's busy flag next to the busy flags of two neighbouring endpoints, so firmware can poll all three with one read.

Top module: `usb_out_ep_handshake`

## Requirements
- R1: After reset the busy flag, the stall flag, the interrupt request and the latched count are all 0, and hs_code is 0.
- R2: A CPU write of any data value to address 1 (count register) sets busy to 1 from the next clock edge.
- R3: A transaction end with good=1, busy=1 and stall=0 clears busy at that edge and latches sie_out_len as the count.
- R4: A transaction end with good=0, busy=1 and stall=0 leaves busy at 1, leaves the count unchanged, raises no interrupt and gives hs_code 0.
- R5: A 1-to-0 change of busy sets irq_req one cycle later. irq_req stays set until firmware writes a 1 to bit 0 of address 2. Writing a 0 there has no effect, and a new set wins over a clear in the same cycle.
- R6: A transaction end with busy=0 and stall=0 is answered NAK. Busy stays 0 and the count is unchanged.
- R7: While stall is 1, every transaction end is answered STALL, whatever the busy and good inputs, and busy is unchanged. Stall is written only through bit 1 of address 0.
- R8: Address 3 reads as fast status: bit 0 = ep0_busy_in, bit 1 = this endpoint's busy, bit 2 = ep1in_busy_in, all other bits 0.
- R9: Address 1 reads the latched count, zero-extended, while busy is 0, and reads 0 while busy is 1.
- R10: hs_code is valid for exactly one cycle after the edge that samples sie_out_end: 1 = ACK, 2 = NAK, 3 = STALL, 0 = none. It is 0 in every other cycle.
- R11: Address 0 reads bit 0 = busy and bit 1 = stall, other bits 0. Bit 0 of a write to address 0 does not change busy. Address 2 reads irq_req in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data for cpu_addr (combinational) |
| sie_out_end | input | 1 | One-cycle strobe at the end of an OUT data packet |
| sie_out_good | input | 1 | Packet passed the accuracy check |
| sie_out_len | input | CNT_W | Received byte count of the packet |
| hs_code | output | 2 | Handshake answer (0 none, 1 ACK, 2 NAK, 3 STALL) |
| ep_busy | output | 1 | Buffer owned by the SIE |
| irq_req | output | 1 | Pending OUT-data interrupt request |
| ep0_busy_in | input | 1 | Busy flag of endpoint 0, mirrored in fast status |
| ep1in_busy_in | input | 1 | Busy flag of the IN endpoint, mirrored in fast status |

## Verification
The bench builds the block with its default parameters: a 7-bit count and an 8-bit register bus. With these values, packets of length 0 and of length 127 (all count bits set) can be driven and read back in full through the count register. A behavioural model runs alongside the design and is compared on every clock. Directed sequences cover unarmed NAKs, corrupted packets while armed, and stall overriding both busy states. They also cover an interrupt clear that lands together with a new falling edge, and every combination of the two mirrored neighbour flags.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_code_e;

  localparam int REG_CTRL  = 0;
  localparam int REG_COUNT = 1;
  localparam int REG_IRQ   = 2;
  localparam int REG_FAST  = 3;

  localparam int CTRL_BUSY_BIT  = 0;
  localparam int CTRL_STALL_BIT = 1;

  // Handshake choice for one finished OUT transaction.
  function automatic hs_code_e hs_decide(input logic stall, input logic busy,
                                         input logic good);
    hs_code_e r;
    if (stall)      r = HS_STALL;
    else if (!busy) r = HS_NAK;
    else if (good)  r = HS_ACK;
    else            r = HS_NONE;
    return r;
  endfunction

  // Buffer is handed back to firmware only on an acknowledged packet.
  function automatic logic takes_packet(input logic stall, input logic busy,
                                        input logic good);
    return !stall && busy && good;
  endfunction

endpackage

// File: rtl/ep_busy_ctrl.sv
module ep_busy_ctrl
  import ep_hs_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_wr,
  input  logic             stall_wr,
  input  logic             stall_wdata,
  input  logic             sie_end,
  input  logic             sie_good,
  input  logic [CNT_W-1:0] sie_len,
  output logic             busy,
  output logic             stall,
  output hs_code_e         hs_code,
  output logic             ack_ev,
  output logic [CNT_W-1:0] count
);

  hs_code_e hs_next;
  logic     busy_next;

  always_comb begin
    hs_next = sie_end ? hs_decide(stall, busy, sie_good) : HS_NONE;
    ack_ev  = sie_end && takes_packet(stall, busy, sie_good);
  end

  // An arming write in the same cycle as an ACK leaves the buffer armed.
  always_comb begin
    busy_next = busy;
    if (ack_ev) busy_next = 1'b0;
    if (arm_wr) busy_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      stall   <= 1'b0;
      hs_code <= HS_NONE;
      count   <= '0;
    end else begin
      busy    <= busy_next;
      hs_code <= hs_next;
      if (stall_wr) stall <= stall_wdata;
      if (ack_ev)   count <= sie_len;
    end
  end

  AST_ARM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> busy); // R2

  AST_BAD_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_end && busy && !sie_good) |=> busy); // R4

  AST_NAK_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_end && !busy) |=> $stable(count)); // R6

  AST_STALL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_end && stall) |=> (hs_code == HS_STALL)); // R7

  AST_STALL_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_wr |=> $stable(stall)); // R7

  AST_HS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code != HS_NONE) |-> $past(sie_end)); // R10

endmodule

// File: rtl/ep_irq_capture.sv
module ep_irq_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic clr_wr,
  output logic busy_fall,
  output logic irq_pend
);

  logic busy_q;

  assign busy_fall = busy_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      busy_q <= busy;
      if (busy_fall)   irq_pend <= 1'b1;
      else if (clr_wr) irq_pend <= 1'b0;
    end
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !clr_wr) |=> irq_pend); // R5

  AST_IRQ_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pend && !busy_fall) |=> !irq_pend); // R5

endmodule

// File: rtl/ep_cpu_regs.sv
module ep_cpu_regs
  import ep_hs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              busy,
  input  logic              stall,
  input  logic              irq_pend,
  input  logic [CNT_W-1:0]  count,
  input  logic              ep0_busy,
  input  logic              ep1in_busy,
  output logic              arm_wr,
  output logic              stall_wr,
  output logic              stall_wdata,
  output logic              irq_clr,
  output logic [DATA_W-1:0] rdata
);

  localparam int CNT_PAD = DATA_W - CNT_W;

  logic unused_wdata;
  assign unused_wdata = ^cpu_wdata;

  always_comb begin
    arm_wr      = cpu_wr && (cpu_addr == ADDR_W'(REG_COUNT));
    stall_wr    = cpu_wr && (cpu_addr == ADDR_W'(REG_CTRL));
    stall_wdata = cpu_wdata[CTRL_STALL_BIT];
    irq_clr     = cpu_wr && (cpu_addr == ADDR_W'(REG_IRQ)) && cpu_wdata[0];
  end

  always_comb begin
    rdata = '0;
    case (cpu_addr)
      ADDR_W'(REG_CTRL): begin
        rdata[CTRL_BUSY_BIT]  = busy;
        rdata[CTRL_STALL_BIT] = stall;
      end
      ADDR_W'(REG_COUNT): rdata = busy ? '0 : {{CNT_PAD{1'b0}}, count};
      ADDR_W'(REG_IRQ):   rdata[0] = irq_pend;
      ADDR_W'(REG_FAST):  rdata[2:0] = {ep1in_busy, busy, ep0_busy};
      default:            rdata = '0;
    endcase
  end

  always_comb begin
    if (cpu_addr == ADDR_W'(REG_COUNT) && busy)
      AST_COUNT_HIDDEN: assert (rdata == '0); // R9
  end

endmodule

// File: rtl/usb_out_ep_handshake.sv
module usb_out_ep_handshake
  import ep_hs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              sie_out_end,
  input  logic              sie_out_good,
  input  logic [CNT_W-1:0]  sie_out_len,
  output logic [1:0]        hs_code,
  output logic              ep_busy,
  output logic              irq_req,
  input  logic              ep0_busy_in,
  input  logic              ep1in_busy_in
);

  // Internal events, named for the assertions.
  logic             arm_wr;
  logic             stall_wr;
  logic             stall_wdata;
  logic             irq_clr;
  logic             ack_ev;
  logic             busy_fall;
  logic             stall;
  logic [CNT_W-1:0] count;
  hs_code_e         hs_q;

  ep_busy_ctrl #(.CNT_W(CNT_W)) u_busy (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_wr     (arm_wr),
    .stall_wr   (stall_wr),
    .stall_wdata(stall_wdata),
    .sie_end    (sie_out_end),
    .sie_good   (sie_out_good),
    .sie_len    (sie_out_len),
    .busy       (ep_busy),
    .stall      (stall),
    .hs_code    (hs_q),
    .ack_ev     (ack_ev),
    .count      (count)
  );

  ep_irq_capture u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (ep_busy),
    .clr_wr   (irq_clr),
    .busy_fall(busy_fall),
    .irq_pend (irq_req)
  );

  ep_cpu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .busy       (ep_busy),
    .stall      (stall),
    .irq_pend   (irq_req),
    .count      (count),
    .ep0_busy   (ep0_busy_in),
    .ep1in_busy (ep1in_busy_in),
    .arm_wr     (arm_wr),
    .stall_wr   (stall_wr),
    .stall_wdata(stall_wdata),
    .irq_clr    (irq_clr),
    .rdata      (cpu_rdata)
  );

  assign hs_code = hs_q;

  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ep_busy) |=> irq_req); // R5

  AST_FALL_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_busy && !ack_ev) |=> ep_busy); // R3

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && !arm_wr) |=> (!ep_busy && hs_code == 2'd1)); // R3

endmodule

// File: tb/test_usb_out_ep_handshake.sv
module test_usb_out_ep_handshake;

  localparam int AW = 2;
  localparam int DW = 8;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          sie_out_end = 1'b0;
  logic          sie_out_good = 1'b0;
  logic [CW-1:0] sie_out_len = '0;
  logic [1:0]    hs_code;
  logic          ep_busy;
  logic          irq_req;
  logic          ep0_busy_in = 1'b0;
  logic          ep1in_busy_in = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit running = 1'b0;

  always #5 clk = ~clk;

  usb_out_ep_handshake #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_usb_out_ep_handshake (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sie_out_end(sie_out_end),
    .sie_out_good(sie_out_good), .sie_out_len(sie_out_len), .hs_code(hs_code),
    .ep_busy(ep_busy), .irq_req(irq_req), .ep0_busy_in(ep0_busy_in),
    .ep1in_busy_in(ep1in_busy_in)
  );

  // Behavioural reference model
  int m_busy, m_stall, m_irq, m_cnt, m_hs, m_prev_busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_stall = 0; m_irq = 0; m_cnt = 0; m_hs = 0; m_prev_busy = 0;
    end else begin
      int nb, ns, ni, nc, nh;
      bit fell;
      nb = m_busy; ns = m_stall; nc = m_cnt; nh = 0;
      fell = (m_prev_busy == 1) && (m_busy == 0);
      if (sie_out_end) begin
        if (m_stall == 1)      nh = 3;
        else if (m_busy == 0)  nh = 2;
        else if (sie_out_good) begin nh = 1; nb = 0; nc = int'(sie_out_len); end
      end
      if (cpu_wr && cpu_addr == 1) nb = 1;
      if (cpu_wr && cpu_addr == 0) ns = int'(cpu_wdata[1]);
      if (fell) ni = 1;
      else if (cpu_wr && cpu_addr == 2 && cpu_wdata[0]) ni = 0;
      else ni = m_irq;
      m_prev_busy = m_busy;
      m_busy = nb; m_stall = ns; m_irq = ni; m_cnt = nc; m_hs = nh;
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return m_busy + 2 * m_stall;
      1: return (m_busy == 1) ? 0 : m_cnt;
      2: return m_irq;
      default: return int'(ep0_busy_in) + 2 * m_busy + 4 * int'(ep1in_busy_in);
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      check("R10 hs_code", int'(hs_code), m_hs);
      check("R3 ep_busy", int'(ep_busy), m_busy);
      check("R5 irq_req", int'(irq_req), m_irq);
      check("R8/R9/R11 cpu_rdata", int'(cpu_rdata), model_rd(int'(cpu_addr)));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input int a, input int d);
    cpu_wr = 1'b1; cpu_addr = AW'(a); cpu_wdata = DW'(d);
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input int a, input string req, input int exp);
    cpu_addr = AW'(a);
    #1;
    check(req, int'(cpu_rdata), exp);
  endtask

  // Drives one transaction end; returns after the answer is visible.
  task automatic pkt(input bit good, input int len, input string req, input int exp_hs);
    sie_out_end = 1'b1; sie_out_good = good; sie_out_len = CW'(len);
    @(negedge clk);
    check(req, int'(hs_code), exp_hs);
    #1;
    sie_out_end = 1'b0; sie_out_good = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    running = 1'b1;
    tick();
    // R1 reset state
    check("R1 busy", int'(ep_busy), 0);
    check("R1 irq", int'(irq_req), 0);
    check("R1 hs", int'(hs_code), 0);
    rd(0, "R1 ctrl", 0);
    rd(1, "R1 count", 0);
    // R6 NAK when unarmed, count untouched
    pkt(1'b1, 12, "R6 unarmed NAK", 2);
    tick();
    rd(1, "R6 count unchanged", 0);
    check("R6 busy stays 0", int'(ep_busy), 0);
    // R2 arm with arbitrary value
    wr(1, 8'h5A);
    check("R2 armed", int'(ep_busy), 1);
    rd(1, "R9 count hidden while busy", 0);
    // R11 ctrl bit0 write has no effect
    wr(0, 8'h01);
    check("R11 busy unaffected", int'(ep_busy), 1);
    rd(0, "R11 ctrl read", 1);
    // R4 corrupted packet
    pkt(1'b0, 55, "R4 no handshake", 0);
    check("R4 busy kept", int'(ep_busy), 1);
    tick(); tick();
    check("R4 no irq", int'(irq_req), 0);
    // R3 good packet
    pkt(1'b1, 37, "R3 ACK", 1);
    check("R3 busy cleared", int'(ep_busy), 0);
    check("R5 irq not yet", int'(irq_req), 0);
    tick();
    check("R5 irq set", int'(irq_req), 1);
    rd(1, "R9 count 37", 37);
    rd(2, "R11 irq read", 1);
    wr(2, 0);
    check("R5 write 0 keeps irq", int'(irq_req), 1);
    wr(2, 1);
    check("R5 cleared", int'(irq_req), 0);
    // re-arm: no false request
    wr(1, 0);
    tick(); tick();
    check("R5 no irq on arm", int'(irq_req), 0);
    pkt(1'b1, 127, "R3 ACK max", 1);
    // clear lands with the falling edge capture: set wins
    cpu_wr = 1'b1; cpu_addr = AW'(2); cpu_wdata = 8'h01;
    tick(); cpu_wr = 1'b0;
    check("R5 set wins", int'(irq_req), 1);
    rd(1, "R9 count 127", 127);
    wr(2, 1);
    wr(1, 3);
    pkt(1'b1, 0, "R3 ACK zero", 1);
    tick();
    rd(1, "R9 count 0", 0);
    wr(2, 1);
    // R7 stall
    wr(0, 8'h02);
    rd(0, "R7 stall read", 2);
    pkt(1'b1, 9, "R7 stall unarmed", 3);
    wr(1, 1);
    pkt(1'b1, 9, "R7 stall armed", 3);
    check("R7 busy kept", int'(ep_busy), 1);
    pkt(1'b0, 9, "R7 stall bad", 3);
    wr(0, 8'h00);
    pkt(1'b1, 21, "R3 ACK after unstall", 1);
    tick();
    // R8 fast status
    for (int k = 0; k < 4; k++) begin
      ep0_busy_in = k[0]; ep1in_busy_in = k[1];
      rd(3, "R8 fast", k[0] + 4 * k[1]);
      tick();
    end
    wr(1, 8'hFF);
    rd(3, "R8 fast own busy", 2 + 4 * int'(ep1in_busy_in) + int'(ep0_busy_in));
    // back-to-back transactions
    pkt(1'b0, 4, "R4 bad", 0);
    pkt(1'b1, 5, "R3 ACK b2b", 1);
    pkt(1'b1, 6, "R6 NAK b2b", 2);
    repeat (4) tick();
    rd(1, "R9 count 5", 5);
    running = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule